// File: doc/BRIEF.md
# Dead-Time and Clamp Gate Generator

This block drives the switches of one phase in a multi-phase buck stage whose half-bridge is built from stacked transistors with two clamp switches at the middle node. It takes the phase-delayed PWM bit and turns it into four registered gate commands: high-side main, low-side main, high clamp and low clamp. Each edge of the PWM bit starts a break-before-make sequence. The outgoing main switch is released first. A programmable dead interval follows. Only then does the incoming main switch turn on.

Rising and falling switching-node transitions each take their dead interval from their own 4-bit setting, counted in cycles of the fast timing clock. A 2-bit policy input chooses how the clamp switches behave. They can stay unused, they can share drive with the mains and fill every dead interval, or they can be driven on their own so that only the clamp on the conducting side is on. A phase enable forces all four commands off so that the phase can be shed. The dead settings and the policy are taken only when a PWM edge is accepted. A change made between edges therefore applies from the next edge on and never shortens an interval that is already running. The PWM input and the configuration are plain control pins. No data flows through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `dt_clamp_gatectl`

## Requirements
- R1: `gate_hi_main` and `gate_lo_main` are never both 1 in the same cycle.
- R2: A rising PWM edge (`pwm_in` goes 0 to 1, sampled at clock edge k) drives every main output off from edge k. The outputs stay off for `dt_rise`+1 cycles. `gate_hi_main` rises at edge k+`dt_rise`+1 (value 0 gives 1 cycle, value 15 gives 16 cycles).
- R3: A falling PWM edge works the same way with `dt_fall`. `gate_hi_main` drops at edge k and `gate_lo_main` rises at edge k+`dt_fall`+1.
- R4: Policy code 1 (plain stacked bridge) keeps both clamp outputs at 0. The unused code 0 behaves exactly as code 1.
- R5: Policy code 2 (shared clamp drive) sets both clamp outputs to 1 in every cycle where both mains are off because of a dead interval, and to 0 while a main conducts.
- R6: Policy code 3 (independent clamps) holds all four outputs at 0 through every dead interval. At the end of the interval, the clamp on the incoming side turns on in the same cycle as its main and stays on as long as that main does. The other clamp stays at 0.
- R7: With `phase_en` at 0, all four outputs are 0 from the next clock edge. Setting `phase_en` back to 1 restores the commands of the current state one edge later.
- R8: `dt_rise`, `dt_fall` and `clamp_mode` are sampled only at the edge that accepts a PWM transition. A change while a dead interval is running does not alter its length or its policy.
- R9: A PWM transition that arrives during a dead interval restarts the sequence for the new level, with the full dead time for that direction counted from the new edge. No main output turns on in between.
- R10: While `rst_n` is 0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; dead times count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Phase-delayed PWM bit; 1 requests high-side conduction |
| phase_en | input | 1 | 1 enables the phase; 0 forces all gates off |
| dt_rise | input | 4 | Dead cycles minus one before a rising switching-node edge |
| dt_fall | input | 4 | Dead cycles minus one before a falling switching-node edge |
| clamp_mode | input | 2 | Clamp policy: 0/1 plain, 2 shared, 3 independent |
| gate_hi_main | output | 1 | High-side main switch command |
| gate_lo_main | output | 1 | Low-side main switch command |
| gate_hi_clamp | output | 1 | High clamp switch command |
| gate_lo_clamp | output | 1 | Low clamp switch command |

## Verification
The bench aims at off-by-one errors in the dead counter at both ends of the 4-bit range. A design that gets these wrong turns the incoming main on one cycle early, which risks shoot-through, or one cycle late. It rewrites the dead setting and the policy in the middle of an interval; a design that samples them continuously would cut the interval short or switch clamp policy halfway through. It toggles the PWM input again before the dead time has expired; a design that fails to restart would turn on the stale side or overlap the two mains. It also checks the clamp outputs cycle by cycle under each policy, including the alias code. A swapped clamp pairing, or clamps left on through an independent-mode dead interval, shows up there.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    CLP_ALIAS  = 2'd0,
    CLP_PLAIN  = 2'd1,
    CLP_SHARED = 2'd2,
    CLP_INDEP  = 2'd3
  } clamp_mode_e;

  typedef struct packed {
    logic hi_main;
    logic lo_main;
    logic hi_clamp;
    logic lo_clamp;
  } gate_cmd_t;

  function automatic clamp_mode_e norm_mode(input logic [1:0] raw);
    clamp_mode_e m;
    m = clamp_mode_e'(raw);
    if (m == CLP_ALIAS) m = CLP_PLAIN;
    return m;
  endfunction

endpackage

// File: rtl/dtg_sequencer.sv
module dtg_sequencer
  import dtg_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dt_rise,
  input  logic [DT_W-1:0] dt_fall,
  input  logic [1:0]      mode_in,
  output logic            side_nx,
  output logic            dead_nx,
  output clamp_mode_e     mode_nx,
  output clamp_mode_e     mode_q
);

  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  logic            side_q;
  logic            dead_q;
  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_nx;
  logic            edge_w;

  assign edge_w = (pwm_in != side_q);

  always_comb begin
    side_nx = side_q;
    dead_nx = dead_q;
    cnt_nx  = cnt_q;
    mode_nx = mode_q;
    if (edge_w) begin
      side_nx = pwm_in;
      dead_nx = 1'b1;
      cnt_nx  = pwm_in ? dt_rise : dt_fall;
      mode_nx = norm_mode(mode_in);
    end else if (dead_q) begin
      if (cnt_q == CNT_ZERO) dead_nx = 1'b0;
      else                   cnt_nx  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      dead_q <= 1'b1;
      cnt_q  <= CNT_ZERO;
      mode_q <= CLP_PLAIN;
    end else begin
      side_q <= side_nx;
      dead_q <= dead_nx;
      cnt_q  <= cnt_nx;
      mode_q <= mode_nx;
    end
  end

endmodule

// File: rtl/dtg_policy.sv
module dtg_policy
  import dtg_pkg::*;
#(
  parameter int N_SIDES = 2
) (
  input  logic        side,
  input  logic        dead,
  input  clamp_mode_e mode,
  output gate_cmd_t   cmd
);

  logic [N_SIDES-1:0] main_v;
  logic [N_SIDES-1:0] clamp_v;

  // index 1 is the high side, index 0 the low side
  for (genvar i = 0; i < N_SIDES; i++) begin : g_side
    logic owns;
    assign owns = (i == 1) ? side : !side;
    assign main_v[i] = owns && !dead;
    always_comb begin
      case (mode)
        CLP_SHARED: clamp_v[i] = dead;
        CLP_INDEP:  clamp_v[i] = owns && !dead;
        default:    clamp_v[i] = 1'b0;
      endcase
    end
  end

  assign cmd.hi_main  = main_v[1];
  assign cmd.lo_main  = main_v[0];
  assign cmd.hi_clamp = clamp_v[1];
  assign cmd.lo_clamp = clamp_v[0];

endmodule

// File: rtl/dt_clamp_gatectl.sv
module dt_clamp_gatectl
  import dtg_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic            phase_en,
  input  logic [DT_W-1:0] dt_rise,
  input  logic [DT_W-1:0] dt_fall,
  input  logic [1:0]      clamp_mode,
  output logic            gate_hi_main,
  output logic            gate_lo_main,
  output logic            gate_hi_clamp,
  output logic            gate_lo_clamp
);

  logic        side_nx;
  logic        dead_nx;
  clamp_mode_e mode_nx;
  clamp_mode_e mode_cur;
  gate_cmd_t   cmd_nx;
  gate_cmd_t   gate_q;

  dtg_sequencer #(.DT_W(DT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_in  (pwm_in),
    .dt_rise (dt_rise),
    .dt_fall (dt_fall),
    .mode_in (clamp_mode),
    .side_nx (side_nx),
    .dead_nx (dead_nx),
    .mode_nx (mode_nx),
    .mode_q  (mode_cur)
  );

  dtg_policy #(.N_SIDES(2)) u_pol (
    .side (side_nx),
    .dead (dead_nx),
    .mode (mode_nx),
    .cmd  (cmd_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= '0;
    else if (phase_en) gate_q <= cmd_nx;
    else               gate_q <= '0;
  end

  assign gate_hi_main  = gate_q.hi_main;
  assign gate_lo_main  = gate_q.lo_main;
  assign gate_hi_clamp = gate_q.hi_clamp;
  assign gate_lo_clamp = gate_q.lo_clamp;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        phase_en,
  input logic        gate_hi_main,
  input logic        gate_lo_main,
  input logic        gate_hi_clamp,
  input logic        gate_lo_clamp,
  input clamp_mode_e mode_cur
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_main && gate_lo_main));

  a_r7_shed_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> !(gate_hi_main || gate_lo_main || gate_hi_clamp || gate_lo_clamp));

  a_r4_plain_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == CLP_PLAIN) |-> !(gate_hi_clamp || gate_lo_clamp));

  a_r5_shared_clamps_in_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == CLP_SHARED && gate_hi_clamp) |-> (gate_lo_clamp && !gate_hi_main && !gate_lo_main));

  a_r6_indep_clamp_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == CLP_INDEP) |-> (gate_hi_clamp == gate_hi_main && gate_lo_clamp == gate_lo_main));

  a_r10_reset_off: assert property (@(posedge clk)
    !rst_n |-> !(gate_hi_main || gate_lo_main || gate_hi_clamp || gate_lo_clamp));

endmodule

bind dt_clamp_gatectl dtg_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase_en      (phase_en),
  .gate_hi_main  (gate_hi_main),
  .gate_lo_main  (gate_lo_main),
  .gate_hi_clamp (gate_hi_clamp),
  .gate_lo_clamp (gate_lo_clamp),
  .mode_cur      (mode_cur)
);

// File: tb/sim_dt_clamp_gatectl.sv
`timescale 1ns/1ps
module sim_dt_clamp_gatectl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       phase_en = 1'b1;
  logic [3:0] dt_rise = 4'd0;
  logic [3:0] dt_fall = 4'd0;
  logic [1:0] clamp_mode = 2'd1;
  logic       g_hm, g_lm, g_hc, g_lc;

  int n_run = 0;
  int n_fail = 0;
  int overlap_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dt_clamp_gatectl u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .phase_en(phase_en),
    .dt_rise(dt_rise), .dt_fall(dt_fall), .clamp_mode(clamp_mode),
    .gate_hi_main(g_hm), .gate_lo_main(g_lm),
    .gate_hi_clamp(g_hc), .gate_lo_clamp(g_lc)
  );

  // R1 monitor, sampled between edges
  always @(negedge clk) if (rst_n && g_hm && g_lm) overlap_seen++;

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected {hi_main, lo_main, hi_clamp, lo_clamp}
  function automatic logic [3:0] expect_g(input int md, input bit side, input bit dead, input bit en);
    logic [3:0] e;
    int m;
    m = (md == 0) ? 1 : md;
    e = 4'b0000;
    if (!en) return e;
    if (!dead) begin
      e[3] = side;
      e[2] = !side;
    end
    if (m == 2 && dead) e[1:0] = 2'b11;
    if (m == 3 && !dead) begin
      e[1] = side;
      e[0] = !side;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp_v);
    logic [3:0] got;
    got = {g_hm, g_lm, g_hc, g_lc};
    n_run++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp_v);
    end
  endtask

  // drive a PWM level, check the whole dead interval and the first conducting cycles
  task automatic edge_seq(input bit lvl, input int d, input int md, input string tag);
    pwm_in = lvl;
    for (int i = 0; i <= d; i++) begin
      tick();
      chk(tag, expect_g(md, lvl, 1'b1, 1'b1));
    end
    tick();
    chk(tag, expect_g(md, lvl, 1'b0, 1'b1));
    tick(2);
    chk(tag, expect_g(md, lvl, 1'b0, 1'b1));
  endtask

  task automatic t_reset;
    tick();
    chk("R10 reset", 4'b0000);
    tick(2);
    chk("R10 reset hold", 4'b0000);
    rst_n = 1'b1;
    tick(3);
    chk("R4 post-reset low", expect_g(1, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_plain;
    clamp_mode = 2'd1; dt_rise = 4'd3; dt_fall = 4'd5;
    edge_seq(1'b1, 3, 1, "R2 rise dt3 / R4");
    edge_seq(1'b0, 5, 1, "R3 fall dt5 / R4");
  endtask

  task automatic t_extremes;
    dt_rise = 4'd0; dt_fall = 4'd15;
    edge_seq(1'b1, 0, 1, "R2 rise dt0");
    edge_seq(1'b0, 15, 1, "R3 fall dt15");
    dt_rise = 4'd15; dt_fall = 4'd0;
    edge_seq(1'b1, 15, 1, "R2 rise dt15");
    edge_seq(1'b0, 0, 1, "R3 fall dt0");
  endtask

  task automatic t_alias;
    clamp_mode = 2'd0; dt_rise = 4'd2; dt_fall = 4'd1;
    edge_seq(1'b1, 2, 0, "R4 alias rise");
    edge_seq(1'b0, 1, 0, "R4 alias fall");
  endtask

  task automatic t_shared;
    clamp_mode = 2'd2; dt_rise = 4'd4; dt_fall = 4'd2;
    edge_seq(1'b1, 4, 2, "R5 shared rise");
    edge_seq(1'b0, 2, 2, "R5 shared fall");
  endtask

  task automatic t_indep;
    clamp_mode = 2'd3; dt_rise = 4'd1; dt_fall = 4'd3;
    edge_seq(1'b1, 1, 3, "R6 indep rise");
    edge_seq(1'b0, 3, 3, "R6 indep fall");
  endtask

  task automatic t_enable;
    // starts in mode 3, low side conducting
    phase_en = 1'b0;
    tick();
    chk("R7 shed", 4'b0000);
    pwm_in = 1'b1;
    tick(6);
    chk("R7 shed while toggling", 4'b0000);
    phase_en = 1'b1;
    tick();
    chk("R7 restore", expect_g(3, 1'b1, 1'b0, 1'b1));
  endtask

  task automatic t_cfg_hold;
    clamp_mode = 2'd3; dt_fall = 4'd9;
    pwm_in = 1'b0;
    tick();
    chk("R8 dead start", 4'b0000);
    dt_fall = 4'd0; clamp_mode = 2'd1;
    for (int i = 0; i < 9; i++) begin
      tick();
      chk("R8 dead kept", 4'b0000);
    end
    tick();
    chk("R8 latched policy", expect_g(3, 1'b0, 1'b0, 1'b1));
    dt_rise = 4'd1;
    edge_seq(1'b1, 1, 1, "R8 new policy at next edge");
  endtask

  task automatic t_retoggle;
    clamp_mode = 2'd1; dt_rise = 4'd6; dt_fall = 4'd2;
    pwm_in = 1'b0;
    tick(4);
    pwm_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 dead before retoggle", 4'b0000);
    end
    edge_seq(1'b0, 2, 1, "R9 restart fall");
  endtask

  task automatic finish_run;
    n_run++;
    if (overlap_seen != 0) begin
      n_fail++;
      $display("FAIL R1 overlap cycles: got %0d expected 0", overlap_seen);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_plain();
    t_extremes();
    t_alias();
    t_shared();
    t_indep();
    t_enable();
    t_cfg_hold();
    t_retoggle();
    done = 1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule